// File: doc/BRIEF.md
# Exception Vector Dispatch Unit

This block performs the processor state change that happens when a fault or trap is taken. Each possible cause has its own request line. When one or more lines are raised in a cycle, the block picks the cause with the highest priority. It then computes the handler entry point by adding a fixed per-cause offset to a programmable handler base address. It loads the new program counter and next program counter, and marks the processor as running in privileged handler mode.

The block also keeps the exception return address register. That register is loaded with the faulting PC only under defined mode conditions. For traps it is moved forward by one instruction word, so the handler returns past the faulting instruction. When the fault comes from outside handler mode, the block sends a one-cycle request to the surrounding core to swap in the shadow register bank. Arithmetic faults have no handler path: taking one raises an error pulse and does not redirect.

All outputs are registered and change on the clock edge that follows the request. The shadow register file, the translation buffers that detect misses, and the handler code itself live outside the block.

Top module: `exc_dispatch`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs become: `new_pc` = `pal_base` + 1, `new_npc` = `pal_base` + 5, `pal_mode` = 1, `exc_addr` = 0, and `redirect`, `shadow_swap`, `arith_err` = 0.
- R2: Cause bits of `fault_req` are arbitrated by index, and the lowest set index wins. The bit positions are: 0 reset, 1 machine check, 2 arithmetic, 3 interrupt, 4 data-miss single, 5 data-miss double, 6 misaligned access, 7 data page fault, 8 data access violation, 9 instruction miss, 10 instruction page fault, 11 instruction access violation, 12 illegal opcode, 13 FP disabled, 14 privileged call, 15 integer overflow. Requests that lose arbitration are dropped.
- R3: On a dispatch, `new_pc` = `pal_base` + offset of the winning cause. The offsets by bit are: 0→0x0001, 1→0x0401, 3→0x0101, 4→0x0201, 5→0x0281, 6→0x0301, 7→0x0381, 8→0x0381, 9→0x0181, 10→0x0181, 11→0x0081, 12→0x0481, 13→0x0581, 14→0x2001, 15→0x0501. With no dispatch, `new_pc` holds its value.
- R4: `new_npc` always equals `new_pc` + 4.
- R5: On a dispatch, `exc_addr` is loaded from `cur_pc` if `restart_req` is 1 or `cur_pal` is 0. Otherwise it keeps its value. With no dispatch it never changes.
- R6: On a dispatch with `trap_skip` = 1, 4 is added to the value chosen under R5 (the captured PC or the held value).
- R7: `shadow_swap` pulses for exactly the cycle after a dispatch whose `cur_pal` was 0, and is 0 at all other times.
- R8: After a dispatch `pal_mode` is bit 0 of the new PC, which is always 1. In cycles without a dispatch it takes the value of `cur_pal`.
- R9: When the arithmetic cause wins, `arith_err` pulses for one cycle. In that case `new_pc`, `new_npc` and `exc_addr` keep their values, and `redirect` and `shadow_swap` stay 0.
- R10: `redirect` is 1 for exactly the cycle after a dispatch, which is a cycle with any request set where the winner is not arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_req | input | 16 | One request strobe per cause (bit map in R2) |
| restart_req | input | 1 | The cause asks for the return address to be captured |
| trap_skip | input | 1 | The cause is a trap; return past the faulting instruction |
| cur_pc | input | PC_W | PC of the faulting instruction |
| cur_pal | input | 1 | Processor is currently in handler mode |
| pal_base | input | PC_W | Handler base address |
| redirect | output | 1 | One-cycle pulse: new PC is valid |
| new_pc | output | PC_W | Handler entry PC |
| new_npc | output | PC_W | Next PC (new_pc + 4) |
| exc_addr | output | PC_W | Exception return address register |
| shadow_swap | output | 1 | One-cycle shadow-bank swap request |
| pal_mode | output | 1 | Handler-mode flag |
| arith_err | output | 1 | One-cycle pulse: unsupported arithmetic fault taken |

## Verification
Two functions can meet in one cycle: arbitration and the arithmetic error path. This happens when the arithmetic bit is raised together with lower-priority causes such as the interrupt, and also together with higher-priority causes such as machine check. The first case must produce only an error pulse with no redirect. The second must produce a normal dispatch to the machine-check offset with no error. The bench sets up both cases directly, and random multi-bit request words repeat them. A behavioural model judges every cycle by scanning the request word for its lowest set bit.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCAUSE = 16;
  localparam int CW     = $clog2(NCAUSE);
  localparam int OFF_W  = 14;

  typedef enum logic [CW-1:0] {
    C_RESET     = 4'd0,
    C_MCHECK    = 4'd1,
    C_ARITH     = 4'd2,
    C_IRQ       = 4'd3,
    C_DMISS1    = 4'd4,
    C_DMISS2    = 4'd5,
    C_MISALIGN  = 4'd6,
    C_DPAGE     = 4'd7,
    C_DACCESS   = 4'd8,
    C_IMISS     = 4'd9,
    C_IPAGE     = 4'd10,
    C_IACCESS   = 4'd11,
    C_BADOP     = 4'd12,
    C_FPOFF     = 4'd13,
    C_PRIVCALL  = 4'd14,
    C_OVERFLOW  = 4'd15
  } cause_e;

  function automatic logic [OFF_W-1:0] vec_offset(input cause_e c);
    logic [OFF_W-1:0] r;
    case (c)
      C_RESET:    r = 14'h0001;
      C_MCHECK:   r = 14'h0401;
      C_ARITH:    r = 14'h0501;
      C_IRQ:      r = 14'h0101;
      C_DMISS1:   r = 14'h0201;
      C_DMISS2:   r = 14'h0281;
      C_MISALIGN: r = 14'h0301;
      C_DPAGE:    r = 14'h0381;
      C_DACCESS:  r = 14'h0381;
      C_IMISS:    r = 14'h0181;
      C_IPAGE:    r = 14'h0181;
      C_IACCESS:  r = 14'h0081;
      C_BADOP:    r = 14'h0481;
      C_FPOFF:    r = 14'h0581;
      C_PRIVCALL: r = 14'h2001;
      C_OVERFLOW: r = 14'h0501;
      default:    r = 14'h0001;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_pkg::*;
#(
  parameter int N  = NCAUSE,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_chain
      if (g == 0) begin : g_first
        assign grant[g] = req[g];
      end else begin : g_rest
        assign grant[g] = req[g] & ~(|req[g-1:0]);
      end
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

  assign any = |req;
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic [CW-1:0]   cause,
  input  logic [PC_W-1:0] base,
  output logic [PC_W-1:0] target,
  output logic [PC_W-1:0] target_next
);
  localparam int PAD = PC_W - OFF_W;
  logic [OFF_W-1:0] off;

  assign off         = vec_offset(cause_e'(cause));
  assign target      = base + {{PAD{1'b0}}, off};
  assign target_next = target + PC_W'(4);
endmodule

// File: rtl/exc_addr_unit.sv
module exc_addr_unit #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic            restart_req,
  input  logic            cur_pal,
  input  logic            trap_skip,
  input  logic [PC_W-1:0] cur_pc,
  output logic [PC_W-1:0] exc_addr
);
  logic [PC_W-1:0] exc_q;
  logic [PC_W-1:0] pick;
  logic            capture;

  assign capture = restart_req | ~cur_pal;
  assign pick    = capture ? cur_pc : exc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_q <= '0;
    end else if (fire) begin
      exc_q <= trap_skip ? pick + PC_W'(4) : pick;
    end
  end

  assign exc_addr = exc_q;

  // without a dispatch the return address must not move
  assert_exc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(exc_q));
  // a trap that captures lands one word past the faulting PC
  assert_trap_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && trap_skip && (restart_req || !cur_pal)) |=> exc_q == $past(cur_pc) + PC_W'(4));
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCAUSE-1:0] fault_req,
  input  logic              restart_req,
  input  logic              trap_skip,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              cur_pal,
  input  logic [PC_W-1:0]   pal_base,
  output logic              redirect,
  output logic [PC_W-1:0]   new_pc,
  output logic [PC_W-1:0]   new_npc,
  output logic [PC_W-1:0]   exc_addr,
  output logic              shadow_swap,
  output logic              pal_mode,
  output logic              arith_err
);
  logic [NCAUSE-1:0] grant;
  logic [CW-1:0]     win;
  logic              any_req;
  logic              is_arith;
  logic              disp;
  logic [PC_W-1:0]   tgt;
  logic [PC_W-1:0]   tgt_nx;
  logic [PC_W-1:0]   rst_tgt;

  logic              redir_q, swap_q, pal_q, err_q;
  logic [PC_W-1:0]   pc_q, npc_q;

  exc_cause_arb #(.N(NCAUSE), .IW(CW)) u_arb (
    .req   (fault_req),
    .grant (grant),
    .idx   (win),
    .any   (any_req)
  );

  exc_vector_gen #(.PC_W(PC_W)) u_vec (
    .cause       (win),
    .base        (pal_base),
    .target      (tgt),
    .target_next (tgt_nx)
  );

  assign is_arith = any_req && (win == CW'(C_ARITH));
  assign disp     = any_req && !is_arith;
  assign rst_tgt  = pal_base + PC_W'(1);

  exc_addr_unit #(.PC_W(PC_W)) u_exc (
    .clk         (clk),
    .rst         (rst),
    .fire        (disp),
    .restart_req (restart_req),
    .cur_pal     (cur_pal),
    .trap_skip   (trap_skip),
    .cur_pc      (cur_pc),
    .exc_addr    (exc_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= rst_tgt;
      npc_q   <= rst_tgt + PC_W'(4);
      pal_q   <= 1'b1;
      redir_q <= 1'b0;
      swap_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      redir_q <= disp;
      swap_q  <= disp & ~cur_pal;
      err_q   <= is_arith;
      if (disp) begin
        pc_q  <= tgt;
        npc_q <= tgt_nx;
        pal_q <= tgt[0];
      end else begin
        pal_q <= cur_pal;
      end
    end
  end

  assign redirect    = redir_q;
  assign new_pc      = pc_q;
  assign new_npc     = npc_q;
  assign shadow_swap = swap_q;
  assign pal_mode    = pal_q;
  assign arith_err   = err_q;

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  assert_grant_present_R2: assert property (@(posedge clk) disable iff (rst)
    (|fault_req) |-> (|grant));
  assert_npc_step_R4: assert property (@(posedge clk) disable iff (rst)
    redirect |-> new_npc == new_pc + PC_W'(4));
  assert_swap_only_outside_R7: assert property (@(posedge clk) disable iff (rst)
    (disp && cur_pal) |=> !shadow_swap);
  assert_swap_needs_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    shadow_swap |-> redirect);
  assert_pal_after_dispatch_R8: assert property (@(posedge clk) disable iff (rst)
    redirect |-> pal_mode);
  assert_arith_no_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    arith_err |-> (!redirect && !shadow_swap));
  assert_arith_holds_pc_R9: assert property (@(posedge clk) disable iff (rst)
    is_arith |=> $stable(new_pc));
  assert_redirect_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !disp |=> !redirect);
endmodule

// File: tb/exc_dispatch_bench.sv
`timescale 1ns/1ps
module exc_dispatch_bench;
  localparam int PW = 32;
  localparam int MAXCYC = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic [15:0]   fault_req;
  logic          restart_req, trap_skip, cur_pal;
  logic [PW-1:0] cur_pc, pal_base;
  logic          redirect, shadow_swap, pal_mode, arith_err;
  logic [PW-1:0] new_pc, new_npc, exc_addr;

  always #2 clk = ~clk;

  exc_dispatch #(.PC_W(PW)) u_exc_dispatch (
    .clk(clk), .rst(rst), .fault_req(fault_req), .restart_req(restart_req),
    .trap_skip(trap_skip), .cur_pc(cur_pc), .cur_pal(cur_pal), .pal_base(pal_base),
    .redirect(redirect), .new_pc(new_pc), .new_npc(new_npc), .exc_addr(exc_addr),
    .shadow_swap(shadow_swap), .pal_mode(pal_mode), .arith_err(arith_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ncyc  = 0;
  bit done  = 0;

  // reference model state
  logic [PW-1:0] m_pc, m_npc, m_exc;
  logic          m_pal, m_swap, m_redir, m_err, m_inrst;

  function automatic int ref_off(input int c);
    case (c)
      0: return 32'h0001;  1: return 32'h0401;  2: return 32'h0501;  3: return 32'h0101;
      4: return 32'h0201;  5: return 32'h0281;  6: return 32'h0301;  7: return 32'h0381;
      8: return 32'h0381;  9: return 32'h0181; 10: return 32'h0181; 11: return 32'h0081;
      12: return 32'h0481; 13: return 32'h0581; 14: return 32'h2001; default: return 32'h0501;
    endcase
  endfunction

  always @(posedge clk) begin
    int w;
    logic [PW-1:0] base_v;
    ncyc++;
    m_inrst = rst;
    if (rst) begin
      m_pc = pal_base + 1; m_npc = pal_base + 5; m_pal = 1; m_exc = 0;
      m_swap = 0; m_redir = 0; m_err = 0;
    end else begin
      w = -1;
      for (int k = 15; k >= 0; k--) if (fault_req[k]) w = k;
      m_swap = 0; m_redir = 0; m_err = 0;
      if (w == 2) begin
        m_err = 1; m_pal = cur_pal;
      end else if (w >= 0) begin
        m_redir = 1;
        m_pc = pal_base + PW'(ref_off(w));
        m_npc = m_pc + 4;
        m_pal = 1;
        m_swap = !cur_pal;
        base_v = (restart_req || !cur_pal) ? cur_pc : m_exc;
        m_exc = trap_skip ? base_v + 4 : base_v;
      end else begin
        m_pal = cur_pal;
      end
    end
  end

  task automatic chk(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, ncyc);
    end
  endtask

  always @(negedge clk) begin
    if (ncyc > 0 && !done) begin
      if (m_inrst) begin
        chk("R1 pc", new_pc, m_pc);       chk("R1 npc", new_npc, m_npc);
        chk("R1 exc", exc_addr, m_exc);   chk("R1 pal", PW'(pal_mode), PW'(m_pal));
        chk("R1 pulses", PW'({redirect, shadow_swap, arith_err}), 0);
      end else begin
        chk("R3 new_pc", new_pc, m_pc);
        chk("R4 new_npc", new_npc, m_npc);
        chk("R5/R6 exc_addr", exc_addr, m_exc);
        chk("R7 shadow_swap", PW'(shadow_swap), PW'(m_swap));
        chk("R8 pal_mode", PW'(pal_mode), PW'(m_pal));
        chk("R9 arith_err", PW'(arith_err), PW'(m_err));
        chk("R10 redirect", PW'(redirect), PW'(m_redir));
      end
    end
  end

  task automatic step(input logic [15:0] rq, input logic rr, input logic ts,
                      input logic pal, input logic [PW-1:0] pc);
    fault_req = rq; restart_req = rr; trap_skip = ts; cur_pal = pal; cur_pc = pc;
    @(negedge clk);
    fault_req = '0;
  endtask

  initial begin
    rst = 1; fault_req = '0; restart_req = 0; trap_skip = 0; cur_pal = 1;
    cur_pc = 32'h0000_4000; pal_base = 32'h0010_0000;
    repeat (3) @(negedge clk);
    chk("R1 reset pc base+1", new_pc, 32'h0010_0001);
    rst = 0;
    @(negedge clk);
    // R2: interrupt and arithmetic together -> arithmetic wins, error only
    step(16'h000C, 0, 0, 0, 32'h0000_1000);
    chk("R2 arith over irq err", PW'(arith_err), 1);
    chk("R2 arith over irq no redirect", PW'(redirect), 0);
    chk("R9 pc held", new_pc, 32'h0010_0001);
    // R2: machine check beats arithmetic
    step(16'h0006, 0, 0, 0, 32'h0000_1100);
    chk("R2 mcheck wins", new_pc, 32'h0010_0401);
    chk("R2 mcheck no err", PW'(arith_err), 0);
    // R6: trap from user mode captures PC+4
    step(16'h8000, 0, 1, 0, 32'h0000_2000);
    chk("R6 trap skip", exc_addr, 32'h0000_2004);
    chk("R3 overflow vector", new_pc, 32'h0010_0501);
    // R5: in handler mode, no restart -> hold, skip adds to held value
    step(16'h4000, 0, 1, 1, 32'h0000_3000);
    chk("R6 held plus 4", exc_addr, 32'h0000_2008);
    chk("R7 no swap in handler", PW'(shadow_swap), 0);
    chk("R3 privileged call vector", new_pc, 32'h0010_2001);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [15:0] rq;
      r = $urandom % 16;
      if (r < 7) rq = '0;
      else if (r < 13) rq = 16'(1) << ($urandom % 16);
      else rq = 16'($urandom);
      if ($urandom % 64 == 0) pal_base = $urandom & 32'hFFFF_C000;
      rst = ($urandom % 300 == 0);
      step(rq, 1'($urandom), 1'($urandom), 1'($urandom), $urandom & 32'hFFFF_FFFC);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule